// File: doc/BRIEF.md
# Selectable Sequential Element Stage

This block turns a pair of combinational lookup-table outputs into one storage element whose kind is picked at run time. The choices are an edge-triggered D flip-flop, a JK flip-flop, a gated D latch or a set/reset latch. The stage can also be bypassed, in which case the even lookup-table output goes straight to the stage output. The default build has two independent cells. Each cell takes the outputs of one even/odd pair of lookup tables. The cell output also serves as the feedback source that the lookup tables can select.

A small shared control register sits next to the cells. It holds a global enable, which gates every state update, and a run-in-standby flag, which is stored and read back. It also decodes a self-clearing software-reset bit. That bit clears every stored state and drops the enable in the same clock edge. Each cell has its own 4-bit mode field on a packed input bus. The D latch is modelled as a clocked sample of its gate input, so the whole block lives in one clock domain.

Top module: `seqcell_pair`

## Requirements
- R1: After reset `ctl_rdata` reads 0x00, the global enable is off, and every stored state is 0.
- R2: A control write without bit 0 set stores bit 1 (enable) and bit 6 (run-in-standby). `ctl_rdata` returns those two bits in the same positions, and every other bit, bit 0 included, reads zero.
- R3: A control write with bit 0 set clears every cell's stored state and the whole control register at that clock edge, whatever the cell inputs are. The enable is therefore low from the next cycle.
- R4: With mode code 0 or any code from 5 to 15, `seq_out[i]` equals `lut_even[i]` without a clock edge.
- R5: Mode code 1 (D flip-flop): at each enabled rising edge the state takes `lut_even`, unless `lut_odd` is 1, in which case it clears to 0.
- R6: Mode code 2 (JK): `lut_even` is J and `lut_odd` is K. 00 holds, 01 clears, 10 sets and 11 toggles, at each enabled rising edge.
- R7: Mode code 3 (D latch): while `lut_odd` (the gate) is 1 the state takes `lut_even` at each enabled edge. While the gate is 0 the state holds.
- R8: Mode code 4 (RS latch): `lut_even` sets and `lut_odd` resets. When both are 1 the reset wins.
- R9: In modes 1 to 4 `seq_out[i]` shows the stored state. While the enable is low the state holds for every input pattern.
- R10: Cell i uses mode bits [4i+3:4i], `lut_even[i]` and `lut_odd[i]` only. The other cell is not affected by them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control write data: bit 0 soft reset, bit 1 enable, bit 6 run-in-standby |
| ctl_rdata | output | 8 | Control register read value |
| seq_mode | input | 4*NUM_CELLS | Per-cell mode codes, cell i at bits [4i+3:4i] |
| lut_even | input | NUM_CELLS | Even lookup-table output per cell |
| lut_odd | input | NUM_CELLS | Odd lookup-table output per cell |
| seq_out | output | NUM_CELLS | Stage output per cell, also used as the feedback source |

## Verification
The assertions assume that every input changes only between clock edges, that `ctl_wr` is a single-cycle pulse, and that the mode field of a cell stays steady across the edge on which a transition is checked. The stimulus follows these rules. All inputs are driven on the falling edge. Each control write holds the strobe for exactly one rising edge. A mode changes only while the enable is off or before the first enabled edge of a scenario. Every storage-mode scenario starts from a known state, set up by a soft reset.

// File: rtl/seqcell_pkg.sv
package seqcell_pkg;
   localparam int MODE_W   = 4;
   localparam int CTRL_W   = 8;
   localparam int BIT_CLR  = 0;
   localparam int BIT_EN   = 1;
   localparam int BIT_STBY = 6;

   typedef enum logic [MODE_W-1:0] {
      MODE_OFF  = 4'd0,
      MODE_DFF  = 4'd1,
      MODE_JK   = 4'd2,
      MODE_DLAT = 4'd3,
      MODE_RS   = 4'd4
   } seq_mode_e;

   function automatic logic is_storage(input logic [MODE_W-1:0] m);
      return (m == MODE_DFF) || (m == MODE_JK) || (m == MODE_DLAT) || (m == MODE_RS);
   endfunction

   // next state for a storage mode; a = even input, b = odd input
   function automatic logic next_state(input logic [MODE_W-1:0] m,
                                       input logic st, input logic a, input logic b);
      logic r;
      r = st;
      case (m)
         MODE_DFF:  r = b ? 1'b0 : a;
         MODE_JK:   case ({a, b})
                       2'b00: r = st;
                       2'b01: r = 1'b0;
                       2'b10: r = 1'b1;
                       default: r = ~st;
                    endcase
         MODE_DLAT: r = b ? a : st;
         MODE_RS:   r = b ? 1'b0 : (a ? 1'b1 : st);
         default:   r = st;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/seqcell_ctrl.sv
module seqcell_ctrl
   import seqcell_pkg::*;
#(
   parameter int W = CTRL_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] rdata_o,
   output logic         en_o,
   output logic         clr_o
);
   generate
      if (W <= BIT_STBY) begin : g_bad_w
         $error("seqcell_ctrl: W too small for the control bits");
      end
   endgenerate

   logic en_q, stby_q;

   assign clr_o = wr_i & wdata_i[BIT_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         stby_q <= 1'b0;
      end else if (clr_o) begin
         en_q   <= 1'b0;
         stby_q <= 1'b0;
      end else if (wr_i) begin
         en_q   <= wdata_i[BIT_EN];
         stby_q <= wdata_i[BIT_STBY];
      end
   end

   always_comb begin
      rdata_o           = '0;
      rdata_o[BIT_EN]   = en_q;
      rdata_o[BIT_STBY] = stby_q;
   end

   assign en_o = en_q;

   AST_CLR_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      clr_o |=> (!en_o && rdata_o == '0)); // R3
   AST_NO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(rdata_o)); // R2
endmodule

// File: rtl/seqcell_core.sv
module seqcell_core
   import seqcell_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              clr_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              even_i,
   input  logic              odd_i,
   output logic              q_o
);
   logic state_q;
   logic state_d;
   logic store;

   assign store   = is_storage(mode_i);
   assign state_d = next_state(mode_i, state_q, even_i, odd_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= 1'b0;
      else if (clr_i)
         state_q <= 1'b0;
      else if (en_i && store)
         state_q <= state_d;
   end

   assign q_o = store ? state_q : even_i;

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !state_q); // R3
   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !clr_i) |=> $stable(state_q)); // R9
   AST_DFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !clr_i && mode_i == MODE_DFF && odd_i) |=> !state_q); // R5
   AST_JK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !clr_i && mode_i == MODE_JK && even_i && odd_i) |=> state_q != $past(state_q)); // R6
   AST_LATCH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !clr_i && mode_i == MODE_DLAT && !odd_i) |=> $stable(state_q)); // R7
   AST_RS_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !clr_i && mode_i == MODE_RS && odd_i) |=> !state_q); // R8
endmodule

// File: rtl/seqcell_pair.sv
module seqcell_pair
   import seqcell_pkg::*;
#(
   parameter int NUM_CELLS = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ctl_wr,
   input  logic [CTRL_W-1:0]           ctl_wdata,
   output logic [CTRL_W-1:0]           ctl_rdata,
   input  logic [NUM_CELLS*MODE_W-1:0] seq_mode,
   input  logic [NUM_CELLS-1:0]        lut_even,
   input  logic [NUM_CELLS-1:0]        lut_odd,
   output logic [NUM_CELLS-1:0]        seq_out
);
   generate
      if (NUM_CELLS < 1) begin : g_bad_n
         $error("seqcell_pair: NUM_CELLS must be at least 1");
      end
   endgenerate

   logic en, clr;

   seqcell_ctrl #(.W(CTRL_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (ctl_wr),
      .wdata_i(ctl_wdata),
      .rdata_o(ctl_rdata),
      .en_o   (en),
      .clr_o  (clr)
   );

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      seqcell_core u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .en_i  (en),
         .clr_i (clr),
         .mode_i(seq_mode[i*MODE_W +: MODE_W]),
         .even_i(lut_even[i]),
         .odd_i (lut_odd[i]),
         .q_o   (seq_out[i])
      );
   end
endmodule

// File: tb/sim_seqcell_pair.sv
module sim_seqcell_pair;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic [7:0] ctl_rdata;
   logic [7:0] seq_mode = '0;
   logic [1:0] lut_even = '0;
   logic [1:0] lut_odd = '0;
   logic [1:0] seq_out;
   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   seqcell_pair #(.NUM_CELLS(2)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .seq_mode(seq_mode), .lut_even(lut_even),
      .lut_odd(lut_odd), .seq_out(seq_out)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [7:0] d);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = d;
      @(posedge clk); #1;
      ctl_wr = 1'b0; ctl_wdata = '0;
   endtask

   task automatic cyc0(input logic e, input logic o);
      @(negedge clk);
      lut_even[0] = e; lut_odd[0] = o;
      @(posedge clk); #1;
   endtask

   task automatic set_mode0(input logic [3:0] m);
      @(negedge clk);
      seq_mode[3:0] = m;
   endtask

   task automatic start_mode(input logic [3:0] m);
      wr_ctl(8'h01);
      set_mode0(m);
      wr_ctl(8'h02);
   endtask

   task automatic t_reset;
      chk("R1 rdata", ctl_rdata, 8'h00);
      cyc0(1'b0, 1'b0);
      set_mode0(4'd1);
      #1 chk("R1 state", {7'd0, seq_out[0]}, 8'h00);
      set_mode0(4'd0);
   endtask

   task automatic t_ctrl;
      wr_ctl(8'hFE);
      chk("R2 masked", ctl_rdata, 8'h42);
      wr_ctl(8'h40);
      chk("R2 stby only", ctl_rdata, 8'h40);
      wr_ctl(8'h00);
   endtask

   task automatic t_swrst;
      start_mode(4'd1);
      cyc0(1'b1, 1'b0);
      chk("R3 pre", {7'd0, seq_out[0]}, 8'h01);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = 8'h43;
      @(posedge clk); #1;
      ctl_wr = 1'b0; ctl_wdata = '0;
      chk("R3 state", {7'd0, seq_out[0]}, 8'h00);
      chk("R3 rdata", ctl_rdata, 8'h00);
      cyc0(1'b1, 1'b0);
      chk("R3 en low", {7'd0, seq_out[0]}, 8'h00);
   endtask

   task automatic t_bypass;
      logic [3:0] codes [3] = '{4'd0, 4'd7, 4'd15};
      wr_ctl(8'h02);
      for (int k = 0; k < 3; k++) begin
         set_mode0(codes[k]);
         lut_even[0] = 1'b1; lut_odd[0] = 1'b0;
         #1 chk("R4 hi", {7'd0, seq_out[0]}, 8'h01);
         lut_even[0] = 1'b0; lut_odd[0] = 1'b1;
         #1 chk("R4 lo", {7'd0, seq_out[0]}, 8'h00);
      end
      wr_ctl(8'h00);
   endtask

   task automatic t_dff;
      start_mode(4'd1);
      cyc0(1, 0); chk("R5 d1", {7'd0, seq_out[0]}, 8'h01);
      cyc0(0, 0); chk("R5 d0", {7'd0, seq_out[0]}, 8'h00);
      cyc0(1, 0); chk("R5 d1b", {7'd0, seq_out[0]}, 8'h01);
      cyc0(1, 1); chk("R5 clear", {7'd0, seq_out[0]}, 8'h00);
   endtask

   task automatic t_jk;
      start_mode(4'd2);
      cyc0(1, 0); chk("R6 set", {7'd0, seq_out[0]}, 8'h01);
      cyc0(0, 0); chk("R6 hold", {7'd0, seq_out[0]}, 8'h01);
      cyc0(1, 1); chk("R6 tog0", {7'd0, seq_out[0]}, 8'h00);
      cyc0(1, 1); chk("R6 tog1", {7'd0, seq_out[0]}, 8'h01);
      cyc0(0, 1); chk("R6 clr", {7'd0, seq_out[0]}, 8'h00);
   endtask

   task automatic t_latch;
      start_mode(4'd3);
      cyc0(1, 1); chk("R7 open1", {7'd0, seq_out[0]}, 8'h01);
      cyc0(0, 0); chk("R7 closed", {7'd0, seq_out[0]}, 8'h01);
      cyc0(0, 1); chk("R7 open0", {7'd0, seq_out[0]}, 8'h00);
      cyc0(1, 0); chk("R7 closed0", {7'd0, seq_out[0]}, 8'h00);
   endtask

   task automatic t_rs;
      start_mode(4'd4);
      cyc0(1, 0); chk("R8 set", {7'd0, seq_out[0]}, 8'h01);
      cyc0(0, 0); chk("R8 hold", {7'd0, seq_out[0]}, 8'h01);
      cyc0(0, 1); chk("R8 reset", {7'd0, seq_out[0]}, 8'h00);
      cyc0(1, 0); chk("R8 set2", {7'd0, seq_out[0]}, 8'h01);
      cyc0(1, 1); chk("R8 both", {7'd0, seq_out[0]}, 8'h00);
   endtask

   task automatic t_hold;
      start_mode(4'd1);
      cyc0(1, 0);
      wr_ctl(8'h00);
      cyc0(0, 1); chk("R9 dff hold", {7'd0, seq_out[0]}, 8'h01);
      set_mode0(4'd2);
      cyc0(1, 1); chk("R9 jk hold", {7'd0, seq_out[0]}, 8'h01);
   endtask

   task automatic t_indep;
      wr_ctl(8'h01);
      @(negedge clk);
      seq_mode = 8'h01;
      wr_ctl(8'h02);
      @(negedge clk);
      lut_even = 2'b01; lut_odd = 2'b10;
      @(posedge clk); #1;
      chk("R10 cell0 stores", {7'd0, seq_out[0]}, 8'h01);
      chk("R10 cell1 bypass", {7'd0, seq_out[1]}, 8'h00);
      @(negedge clk);
      lut_even = 2'b10; lut_odd = 2'b00;
      #1 chk("R10 cell1 follows", {7'd0, seq_out[1]}, 8'h01);
      chk("R10 cell0 kept", {7'd0, seq_out[0]}, 8'h01);
      @(negedge clk);
      seq_mode = 8'h10;
      lut_even = 2'b11; lut_odd = 2'b00;
      @(posedge clk); #1;
      chk("R10 cell1 dff", {7'd0, seq_out[1]}, 8'h01);
      chk("R10 cell0 bypass", {7'd0, seq_out[0]}, 8'h01);
      wr_ctl(8'h00);
   endtask

   initial begin
      #10 rst_n = 1'b1;
      t_reset;
      t_ctrl;
      t_swrst;
      t_bypass;
      t_dff;
      t_jk;
      t_latch;
      t_rs;
      t_hold;
      t_indep;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule